// File: doc/BRIEF.md
# Delegated Interrupt Enable/Pending Register Unit

This block stores the machine-level interrupt-enable and interrupt-pending registers of a hart. It also presents the supervisor-level windows onto them. The supervisor registers have no storage of their own. Each one is a filtered view of a machine register, gated bit by bit by a machine interrupt-delegation mask that arrives as an input. In the pending view, a delegated machine-level software, timer or external pending bit folds down into the matching supervisor bit position, two places lower.

Software reaches the unit through a simple register port. The port carries a 12-bit address, a 64-bit write value, a write strobe and a read strobe. Read data is combinational from the current register state. Writes land on the next rising clock edge, and each write is legalized according to the view it targets. Two hardware inputs drive the machine timer and machine external pending bits. They are sampled on every cycle and override any software write to those bits.

Top module: `irq_csr_view`

## Requirements
- R1: A synchronous active-high reset clears both stored registers, so every mapped address then reads zero.
- R2: A read at 0x104 (supervisor enable view) returns machine enable ANDed with the delegation mask, on bits 0, 1, 4, 5, 8 and 9 only. All other bits read zero.
- R3: A read at 0x144 (supervisor pending view) returns bit 9 = (p9&d9)|(p11&d11), bit 5 = (p5&d5)|(p7&d7) and bit 1 = (p1&d1)|(p3&d3), where p is machine pending and d is the delegation mask. Bits 8, 4 and 0 return p&d with no folding, and all other bits read zero.
- R4: A write at 0x104 changes an enable bit among 0, 1, 4, 5, 8 and 9 only where the delegation mask bit is set. Every other enable bit keeps its value.
- R5: A write at 0x144 sets pending bit 1 to (written bit 1 AND delegation bit 1). No other pending bit is changed by it.
- R6: Writes at 0x304 (machine enable) and 0x344 (machine pending) store the value masked to bits 0, 1, 3, 4, 5, 7, 8, 9 and 11 (mask 0xBBB). Reads at these addresses return the stored register directly.
- R7: Pending bit 7 takes the value of hw_timer_pend and pending bit 11 takes the value of hw_ext_pend on every clock edge outside reset, whatever software writes in that cycle.
- R8: csr_rdata is zero when csr_re is low or the address is not one of the four mapped addresses. A write to an unmapped address changes nothing.
- R9: A read in the same cycle as a write returns the old value. The legalized value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 64 | Write value |
| csr_we | input | 1 | Write strobe |
| csr_re | input | 1 | Read strobe |
| csr_rdata | output | 64 | Read data (combinational) |
| deleg_mask | input | 64 | Machine interrupt-delegation mask |
| hw_timer_pend | input | 1 | Hardware machine timer pending level |
| hw_ext_pend | input | 1 | Hardware machine external pending level |

## Verification
Two functions can fall in the same cycle: the hardware sampling of the timer and external pending bits, and a software write through the machine pending address that tries to set those same bits to other values. The bench provokes this by writing all ones at 0x344 while both hardware inputs are low, and all zeros while they are high. It then judges that bits 7 and 11 follow the hardware inputs and that the other writable bits follow the software value. A second overlap, a read in the same cycle as a write to the same register, is judged by requiring the old value before the edge.

// File: rtl/irq_view_pkg.sv
package irq_view_pkg;
  // interrupt bit positions shared by machine registers and supervisor views
  localparam int P_USI = 0;
  localparam int P_SSI = 1;
  localparam int P_MSI = 3;
  localparam int P_UTI = 4;
  localparam int P_STI = 5;
  localparam int P_MTI = 7;
  localparam int P_UEI = 8;
  localparam int P_SEI = 9;
  localparam int P_MEI = 11;
  // each machine-level bit sits this far above its supervisor counterpart
  localparam int FOLD_SHIFT = P_MSI - P_SSI;
  // supervisor-visible bits
  localparam int SV_BITS = (1 << P_USI) | (1 << P_SSI) | (1 << P_UTI) |
                           (1 << P_STI) | (1 << P_UEI) | (1 << P_SEI);
  // supervisor bits that receive a folded machine bit
  localparam int FOLD_BITS = (1 << P_SSI) | (1 << P_STI) | (1 << P_SEI);
  // all stored interrupt bits
  localparam int M_BITS = SV_BITS | (1 << P_MSI) | (1 << P_MTI) | (1 << P_MEI);
  // bits driven by hardware inputs
  localparam int HW_BITS = (1 << P_MTI) | (1 << P_MEI);
endpackage

// File: rtl/irq_read_view.sv
module irq_read_view
  import irq_view_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MIE_A = 12'h304,
  parameter logic [ADDR_W-1:0] MIP_A = 12'h344,
  parameter logic [ADDR_W-1:0] SIE_A = 12'h104,
  parameter logic [ADDR_W-1:0] SIP_A = 12'h144
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              re,
  input  logic [XLEN-1:0]   mie,
  input  logic [XLEN-1:0]   mip,
  input  logic [XLEN-1:0]   deleg,
  output logic [XLEN-1:0]   rdata
);
  localparam logic [XLEN-1:0] SV_MASK   = XLEN'(SV_BITS);
  localparam logic [XLEN-1:0] FOLD_MASK = XLEN'(FOLD_BITS);

  logic [XLEN-1:0] sie_v, pend_del, sip_v;

  assign sie_v    = mie & deleg & SV_MASK;
  assign pend_del = mip & deleg;
  assign sip_v    = (pend_del | ((pend_del >> FOLD_SHIFT) & FOLD_MASK)) & SV_MASK;

  always_comb begin
    rdata = '0;
    if (re) begin
      case (addr)
        MIE_A:   rdata = mie;
        MIP_A:   rdata = mip;
        SIE_A:   rdata = sie_v;
        SIP_A:   rdata = sip_v;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_write_legalize.sv
module irq_write_legalize
  import irq_view_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MIE_A = 12'h304,
  parameter logic [ADDR_W-1:0] MIP_A = 12'h344,
  parameter logic [ADDR_W-1:0] SIE_A = 12'h104,
  parameter logic [ADDR_W-1:0] SIP_A = 12'h144
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [XLEN-1:0]   wdata,
  input  logic [XLEN-1:0]   deleg,
  input  logic [XLEN-1:0]   mie_q,
  input  logic [XLEN-1:0]   mip_q,
  input  logic              hw_timer,
  input  logic              hw_ext,
  output logic [XLEN-1:0]   mie_d,
  output logic [XLEN-1:0]   mip_d
);
  localparam logic [XLEN-1:0] SV_MASK  = XLEN'(SV_BITS);
  localparam logic [XLEN-1:0] M_MASK   = XLEN'(M_BITS);
  localparam logic [XLEN-1:0] HW_MASK  = XLEN'(HW_BITS);
  localparam logic [XLEN-1:0] SSI_MASK = XLEN'(1) << P_SSI;

  logic [XLEN-1:0] sie_sel, mip_sw, hw_vec;

  // enable bits the supervisor view may touch
  assign sie_sel = deleg & SV_MASK;

  always_comb begin
    mie_d  = mie_q;
    mip_sw = mip_q;
    if (we) begin
      case (addr)
        MIE_A: mie_d  = wdata & M_MASK;
        MIP_A: mip_sw = wdata & M_MASK;
        SIE_A: mie_d  = (mie_q & ~sie_sel) | (wdata & sie_sel);
        SIP_A: mip_sw = (mip_q & ~SSI_MASK) | (wdata & deleg & SSI_MASK);
        default: ;
      endcase
    end
  end

  // hardware levels win over any software value on their bits
  always_comb begin
    hw_vec = '0;
    hw_vec[P_MTI] = hw_timer;
    hw_vec[P_MEI] = hw_ext;
  end

  assign mip_d = (mip_sw & ~HW_MASK) | hw_vec;
endmodule

// File: rtl/irq_csr_view.sv
module irq_csr_view
  import irq_view_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MIE_A = 12'h304,
  parameter logic [ADDR_W-1:0] MIP_A = 12'h344,
  parameter logic [ADDR_W-1:0] SIE_A = 12'h104,
  parameter logic [ADDR_W-1:0] SIP_A = 12'h144
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic              csr_we,
  input  logic              csr_re,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic [XLEN-1:0]   deleg_mask,
  input  logic              hw_timer_pend,
  input  logic              hw_ext_pend
);
  localparam logic [XLEN-1:0] SV_MASK   = XLEN'(SV_BITS);
  localparam logic [XLEN-1:0] M_MASK    = XLEN'(M_BITS);
  localparam logic [XLEN-1:0] SIP_KEEP  = ~(XLEN'(HW_BITS) | (XLEN'(1) << P_SSI));

  logic [XLEN-1:0] mie_q, mip_q, mie_d, mip_d;

  irq_write_legalize #(
    .XLEN(XLEN), .ADDR_W(ADDR_W),
    .MIE_A(MIE_A), .MIP_A(MIP_A), .SIE_A(SIE_A), .SIP_A(SIP_A)
  ) u_wr (
    .addr(csr_addr), .we(csr_we), .wdata(csr_wdata), .deleg(deleg_mask),
    .mie_q(mie_q), .mip_q(mip_q),
    .hw_timer(hw_timer_pend), .hw_ext(hw_ext_pend),
    .mie_d(mie_d), .mip_d(mip_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mie_q <= '0;
      mip_q <= '0;
    end else begin
      mie_q <= mie_d;
      mip_q <= mip_d;
    end
  end

  irq_read_view #(
    .XLEN(XLEN), .ADDR_W(ADDR_W),
    .MIE_A(MIE_A), .MIP_A(MIP_A), .SIE_A(SIE_A), .SIP_A(SIP_A)
  ) u_rd (
    .addr(csr_addr), .re(csr_re), .mie(mie_q), .mip(mip_q),
    .deleg(deleg_mask), .rdata(csr_rdata)
  );

  // R1: registers are zero after a reset edge
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (mie_q == '0 && mip_q == '0));

  // R2 R3: supervisor views never expose bits outside the six positions
  a_r2_view_bits_only: assert property (@(posedge clk) disable iff (rst)
    (csr_addr == SIE_A || csr_addr == SIP_A) |-> ((csr_rdata & ~SV_MASK) == '0));

  // R4: non-delegated enable bits hold across a supervisor enable write
  a_r4_sie_nondeleg_hold: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_addr == SIE_A) |=>
      (((mie_q ^ $past(mie_q)) & ~($past(deleg_mask) & SV_MASK)) == '0));

  // R5: supervisor pending write touches only the software bit
  a_r5_sip_only_ssi: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_addr == SIP_A) |=> ((mip_q & SIP_KEEP) == ($past(mip_q) & SIP_KEEP)));

  // R6: undefined bit positions never hold a one
  a_r6_undefined_zero: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((mie_q | mip_q) & ~M_MASK) == '0));

  // R7: hardware levels land in the pending register each cycle
  a_r7_hw_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mip_q[P_MTI] == $past(hw_timer_pend) && mip_q[P_MEI] == $past(hw_ext_pend)));

  // R8: no read strobe, no data
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !csr_re |-> (csr_rdata == '0));
endmodule

// File: tb/tb_irq_csr_view.sv
module tb_irq_csr_view;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 10;

  typedef struct packed {
    logic [11:0] a;
    logic [63:0] w;
    logic [63:0] d;
    logic        t;
    logic        e;
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{12'h304, {64{1'b1}},            64'h0,     1'b0, 1'b0},
    '{12'h344, {64{1'b1}},            64'h0,     1'b0, 1'b0},
    '{12'h104, 64'h0,                 64'h222,   1'b0, 1'b0},
    '{12'h144, 64'h0,                 64'h00A,   1'b0, 1'b0},
    '{12'h344, 64'h0,                 64'h888,   1'b1, 1'b1},
    '{12'h104, {64{1'b1}},            {64{1'b1}},1'b1, 1'b1},
    '{12'h144, {64{1'b1}},            {64{1'b1}},1'b0, 1'b1},
    '{12'h304, 64'hFFFF_0000_0000_0123, 64'h111, 1'b0, 1'b1},
    '{12'h144, 64'h2,                 64'h0,     1'b0, 1'b1},
    '{12'h555, {64{1'b1}},            64'hBBB,   1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic        csr_we = 1'b0;
  logic        csr_re = 1'b0;
  logic [63:0] csr_rdata;
  logic [63:0] deleg_mask = '0;
  logic        hw_timer_pend = 1'b0;
  logic        hw_ext_pend = 1'b0;

  int total = 0;
  int bad = 0;
  logic [63:0] m_mie = '0;
  logic [63:0] m_mip = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_csr_view dut (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_re(csr_re), .csr_rdata(csr_rdata),
    .deleg_mask(deleg_mask), .hw_timer_pend(hw_timer_pend), .hw_ext_pend(hw_ext_pend)
  );

  // expected read value from the requirements (R2 R3 R6 R8)
  function automatic logic [63:0] exp_read(logic [11:0] a, logic [63:0] ie,
                                           logic [63:0] ip, logic [63:0] d);
    logic [63:0] r;
    logic [63:0] pd;
    r  = '0;
    pd = ip & d;
    case (a)
      12'h304: r = ie;
      12'h344: r = ip;
      12'h104: begin
        r[0] = ie[0] & d[0]; r[1] = ie[1] & d[1]; r[4] = ie[4] & d[4];
        r[5] = ie[5] & d[5]; r[8] = ie[8] & d[8]; r[9] = ie[9] & d[9];
      end
      12'h144: begin
        r[9] = pd[9] | pd[11]; r[5] = pd[5] | pd[7]; r[1] = pd[1] | pd[3];
        r[8] = pd[8]; r[4] = pd[4]; r[0] = pd[0];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // model update from R4 R5 R6 R7
  task automatic model_write(logic [11:0] a, logic [63:0] w, logic [63:0] d,
                             logic t, logic e);
    case (a)
      12'h304: m_mie = w & 64'hBBB;
      12'h344: m_mip = w & 64'hBBB;
      12'h104: begin
        if (d[0]) m_mie[0] = w[0];
        if (d[1]) m_mie[1] = w[1];
        if (d[4]) m_mie[4] = w[4];
        if (d[5]) m_mie[5] = w[5];
        if (d[8]) m_mie[8] = w[8];
        if (d[9]) m_mie[9] = w[9];
      end
      12'h144: m_mip[1] = w[1] & d[1];
      default: ;
    endcase
    m_mip[7]  = t;
    m_mip[11] = e;
  endtask

  task automatic do_write(logic [11:0] a, logic [63:0] w, logic [63:0] d,
                          logic t, logic e);
    @(negedge clk);
    csr_addr = a; csr_wdata = w; csr_we = 1'b1; csr_re = 1'b0;
    deleg_mask = d; hw_timer_pend = t; hw_ext_pend = e;
    @(posedge clk);
    #1;
    csr_we = 1'b0;
    model_write(a, w, d, t, e);
  endtask

  task automatic do_read(logic [11:0] a, string req);
    csr_addr = a; csr_re = 1'b1;
    #1;
    check(req, csr_rdata, exp_read(a, m_mie, m_mip, deleg_mask));
    csr_re = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    do_read(12'h304, "R1 enable");
    do_read(12'h344, "R1 pending");
    deleg_mask = {64{1'b1}};
    do_read(12'h104, "R1 sup enable");
    do_read(12'h144, "R1 sup pending");

    // table walk: write then read all four views
    for (int i = 0; i < N_VEC; i++) begin
      do_write(VECS[i].a, VECS[i].w, VECS[i].d, VECS[i].t, VECS[i].e);
      do_read(12'h104, "R2 R4 sup enable");
      do_read(12'h144, "R3 R5 sup pending");
      do_read(12'h304, "R6 enable");
      do_read(12'h344, "R6 R7 pending");
    end

    // R8: read strobe low gives zero
    @(negedge clk);
    csr_addr = 12'h304; csr_re = 1'b0;
    #1;
    check("R8 strobe low", csr_rdata, 64'h0);
    // R8: unmapped address reads zero
    csr_addr = 12'h345; csr_re = 1'b1;
    #1;
    check("R8 unmapped", csr_rdata, 64'h0);
    csr_re = 1'b0;

    // R7: software write collides with hardware levels
    do_write(12'h344, {64{1'b1}}, 64'h0, 1'b0, 1'b0);
    do_read(12'h344, "R7 collide sw ones");
    check("R7 bits 7/11 low", csr_rdata & 64'h880, 64'h0);
    csr_re = 1'b1; csr_addr = 12'h344; #1;
    check("R7 bits 7/11 low", csr_rdata & 64'h880, 64'h0);
    check("R7 others set", csr_rdata, 64'h33B);
    csr_re = 1'b0;
    do_write(12'h344, 64'h0, 64'h0, 1'b1, 1'b1);
    csr_re = 1'b1; csr_addr = 12'h344; #1;
    check("R7 collide sw zeros", csr_rdata, 64'h880);
    csr_re = 1'b0;

    // R5: non-delegated software bit stays zero, delegated one sets
    do_write(12'h144, 64'h2, 64'h0, 1'b1, 1'b1);
    csr_re = 1'b1; csr_addr = 12'h344; #1;
    check("R5 ssi not delegated", csr_rdata, 64'h880);
    csr_re = 1'b0;
    do_write(12'h144, 64'h2, 64'h2, 1'b1, 1'b1);
    csr_re = 1'b1; csr_addr = 12'h344; #1;
    check("R5 ssi delegated", csr_rdata, 64'h882);
    csr_re = 1'b0;

    // R9: same-cycle read returns old value, next cycle the new one
    @(negedge clk);
    csr_addr = 12'h304; csr_wdata = 64'h0; csr_we = 1'b1; csr_re = 1'b1;
    #1;
    check("R9 old before edge", csr_rdata, m_mie);
    @(posedge clk);
    #1;
    csr_we = 1'b0;
    model_write(12'h304, 64'h0, deleg_mask, hw_timer_pend, hw_ext_pend);
    check("R9 new after edge", csr_rdata, 64'h0);
    csr_re = 1'b0;

    // R1: reset mid-run clears state
    do_write(12'h304, {64{1'b1}}, 64'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    m_mie = '0; m_mip = '0;
    do_read(12'h304, "R1 enable after reset");
    do_read(12'h344, "R1 pending after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule